// File: doc/BRIEF.md
# BCD Clock-Calendar Timekeeper

This block keeps wall-clock time and a calendar in binary-coded decimal. It advances on a one-cycle tick input that arrives once per second, for example from a prescaler elsewhere on the chip. One tick updates seconds, minutes, hours, day of week, date, month and a two-digit year in a single clock edge. The carry ripples through every unit that rolls over. Hours can be kept in a 24-hour format or in a 12-hour format with a PM flag. The date wraps at the true end of each month, and February has 29 days in every year that is a multiple of four.

Every field is a byte that software-side logic can read through a combinational read port and load through a byte-write port. A run/stop bit in a control byte freezes counting without blocking writes. After each counted second the block raises a one-cycle strobe so that alarm comparison logic can sample the fresh time.

Top module: `bcd_timekeeper`

## Requirements
- R1: The register map is: address 0 seconds (bits 6:0), 1 minutes (bits 6:0), 2 hours (bits 6:0), 3 day of week (bits 2:0), 4 date (bits 5:0), 5 month (bits 4:0), 6 year (bits 7:0), 7 control (bit 7 only). Bits outside these fields always read back 0, whatever was written to them.
- R2: Seconds and minutes count in BCD from 00 to 59. Each wraps to 00 after 59 and carries into the next field.
- R3: When hours bit 6 is 0 (24-hour format), bits 5:0 count BCD 00 to 23. The hours field wraps from 23 to 00 with a carry into the day.
- R4: When hours bit 6 is 1 (12-hour format), bit 5 is PM and bits 4:0 hold BCD 01 to 12. The hour 11 becomes 12 with PM toggled. The hour 12 becomes 01 with PM kept. Only the step from PM 11 to AM 12 carries into the day.
- R5: Day of week counts 1 to 7 and returns to 1 after 7 on each day carry, independently of the date.
- R6: The date wraps to 01 with a month carry after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R7: In February the date wraps after 29 when the year (00 to 99) is divisible by 4, and after 28 otherwise.
- R8: The month wraps from 12 to 01 with a carry into the year. The year wraps from 99 to 00.
- R9: While control bit 7 is 1, ticks are ignored and no time field changes, but writes still load. Control bit 7 at 0 lets ticks count.
- R10: A write loads the addressed field at the next clock edge. When a tick arrives in the same cycle, the written value wins for that field, and the other fields take their tick update.
- R11: The strobe output is high for exactly the one cycle that follows each edge on which a tick was counted, and it is low otherwise.
- R12: After reset the fields read 00:00:00 in 24-hour format, day 1, date 01, month 01, year 00, with counting enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 3 | Register selected for writing |
| wr_data_i | input | 8 | Byte to write |
| rd_addr_i | input | 3 | Register selected for reading |
| rd_data_o | output | 8 | Selected register, combinational |
| sec_strobe_o | output | 1 | Pulse after each counted second |

## Verification
The hardest conditions to reach are the ones where a single tick must ripple from seconds all the way up to the year. Examples are New Year's Eve, and the end of February in every one of the hundred years with and without a leap day. Waiting for these boundaries in real time is impossible. The bench therefore loads every field directly to one second before the boundary and then issues one tick. It sweeps all hundred years this way, computing the expected leap-day outcome from the plain year number. It also places a write and a tick in the same cycle to exercise the precedence rule at a carry point.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_REGS = 8;

  localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd7;

  typedef struct packed {
    logic       carry;
    logic [6:0] hour;
  } hour_step_t;

  // Add one to a two-digit BCD byte.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int bcd_to_int(input logic [7:0] v);
    bcd_to_int = int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bcd);
    is_leap = (bcd_to_int(year_bcd) % 4) == 0;
  endfunction

  // Last date of a month, BCD.
  function automatic logic [7:0] month_end(input logic [7:0] mon_bcd,
                                           input logic [7:0] year_bcd);
    case (mon_bcd)
      8'h02:                      month_end = is_leap(year_bcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

  // One-hour advance in either format; carry marks a new day.
  function automatic hour_step_t hour_step(input logic [6:0] h);
    hour_step_t r;
    logic [7:0] inc;
    r = '0;
    if (h[6]) begin
      inc = bcd_inc({3'b000, h[4:0]});
      if (h[4:0] == 5'h11) begin
        r.hour  = {1'b1, ~h[5], 5'h12};
        r.carry = h[5];
      end else if (h[4:0] >= 5'h12) begin
        r.hour = {1'b1, h[5], 5'h01};
      end else begin
        r.hour = {1'b1, h[5], inc[4:0]};
      end
    end else begin
      inc = bcd_inc({2'b00, h[5:0]});
      if (h[5:0] >= 6'h23) begin
        r.hour  = 7'h00;
        r.carry = 1'b1;
      end else begin
        r.hour = {1'b0, inc[5:0]};
      end
    end
    hour_step = r;
  endfunction

endpackage

// File: rtl/tk_roll_counter.sv
module tk_roll_counter #(
  parameter int         W     = 7,
  parameter logic [7:0] LO    = 8'h00,
  parameter logic [7:0] HI    = 8'h59,
  parameter logic [7:0] MASK  = 8'h7F,
  parameter logic [7:0] RST_V = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         wr_i,
  input  logic [7:0]   wr_data_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  import tk_pkg::*;

  logic [7:0] q8;
  logic       at_top;
  logic [7:0] nxt8;

  assign q8      = 8'(q_o);
  assign at_top  = q8 >= HI;
  assign nxt8    = at_top ? LO : bcd_inc(q8);
  assign carry_o = adv_i & at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= W'(RST_V);
    else if (wr_i)   q_o <= W'(wr_data_i & MASK);
    else if (adv_i)  q_o <= W'(nxt8);
  end

  // R2 (also R5, R8): the top of the range wraps to the bottom
  a_r2_wrap_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && q8 == HI) |=> (8'(q_o) == LO));

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (8'(q_o) == ($past(wr_data_i) & MASK)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_i) |=> $stable(q_o));

endmodule

// File: rtl/tk_hour_unit.sv
module tk_hour_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [6:0] q_o,
  output logic       carry_o
);
  import tk_pkg::*;

  hour_step_t step;

  assign step    = hour_step(q_o);
  assign carry_o = adv_i & step.carry;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 7'h00;
    else if (wr_i)   q_o <= wr_data_i[6:0];
    else if (adv_i)  q_o <= step.hour;
  end

  a_r3_midnight_24h: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && q_o == 7'h23) |=> (q_o == 7'h00));

  a_r4_eleven_to_twelve: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && q_o[6] && q_o[4:0] == 5'h11)
      |=> (q_o[4:0] == 5'h12 && q_o[5] != $past(q_o[5]) && q_o[6]));

  a_r4_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && q_o[6] && q_o[4:0] == 5'h12)
      |=> (q_o[4:0] == 5'h01 && $stable(q_o[6:5])));

endmodule

// File: rtl/tk_date_unit.sv
module tk_date_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic [4:0] month_i,
  input  logic [7:0] year_i,
  output logic [5:0] q_o,
  output logic       carry_o
);
  import tk_pkg::*;

  logic [7:0] last_day;
  logic [7:0] q8;
  logic       at_end;

  assign q8       = {2'b00, q_o};
  assign last_day = month_end({3'b000, month_i}, year_i);
  assign at_end   = q8 >= last_day;
  assign carry_o  = adv_i & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 6'h01;
    else if (wr_i)   q_o <= wr_data_i[5:0];
    else if (adv_i)  q_o <= at_end ? 6'h01 : 6'(bcd_inc(q8));
  end

  a_r6_roll_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_o && !wr_i) |=> (q_o == 6'h01));

  a_r7_feb_leap_day: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && month_i == 5'h02 && q_o == 6'h28 && is_leap(year_i))
      |=> (q_o == 6'h29));

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       sec_strobe_o
);
  import tk_pkg::*;

  logic [NUM_REGS-1:0] wr_hit;
  logic                halt_q;

  // named carry chain
  logic adv_sec, carry_sec, carry_min, carry_hour;
  logic carry_date, carry_month, carry_dow, carry_year;

  logic [6:0] sec_q, min_q, hour_q;
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] month_q;
  logic [7:0] year_q;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      wr_hit[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  assign adv_sec = tick_i & ~halt_q;

  tk_roll_counter #(.W(7), .LO(8'h00), .HI(8'h59), .MASK(8'h7F), .RST_V(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_sec), .wr_i(wr_hit[A_SEC]),
    .wr_data_i(wr_data_i), .q_o(sec_q), .carry_o(carry_sec));

  tk_roll_counter #(.W(7), .LO(8'h00), .HI(8'h59), .MASK(8'h7F), .RST_V(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .adv_i(carry_sec), .wr_i(wr_hit[A_MIN]),
    .wr_data_i(wr_data_i), .q_o(min_q), .carry_o(carry_min));

  tk_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .adv_i(carry_min), .wr_i(wr_hit[A_HOUR]),
    .wr_data_i(wr_data_i), .q_o(hour_q), .carry_o(carry_hour));

  tk_roll_counter #(.W(3), .LO(8'h01), .HI(8'h07), .MASK(8'h07), .RST_V(8'h01)) u_dow (
    .clk(clk), .rst_n(rst_n), .adv_i(carry_hour), .wr_i(wr_hit[A_DOW]),
    .wr_data_i(wr_data_i), .q_o(dow_q), .carry_o(carry_dow));

  tk_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .adv_i(carry_hour), .wr_i(wr_hit[A_DATE]),
    .wr_data_i(wr_data_i), .month_i(month_q), .year_i(year_q),
    .q_o(date_q), .carry_o(carry_date));

  tk_roll_counter #(.W(5), .LO(8'h01), .HI(8'h12), .MASK(8'h1F), .RST_V(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .adv_i(carry_date), .wr_i(wr_hit[A_MONTH]),
    .wr_data_i(wr_data_i), .q_o(month_q), .carry_o(carry_month));

  tk_roll_counter #(.W(8), .LO(8'h00), .HI(8'h99), .MASK(8'hFF), .RST_V(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .adv_i(carry_month), .wr_i(wr_hit[A_YEAR]),
    .wr_data_i(wr_data_i), .q_o(year_q), .carry_o(carry_year));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q       <= 1'b0;
      sec_strobe_o <= 1'b0;
    end else begin
      if (wr_hit[A_CTRL]) halt_q <= wr_data_i[7];
      sec_strobe_o <= adv_sec;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_SEC:   rd_data_o = {1'b0, sec_q};
      A_MIN:   rd_data_o = {1'b0, min_q};
      A_HOUR:  rd_data_o = {1'b0, hour_q};
      A_DOW:   rd_data_o = {5'b0, dow_q};
      A_DATE:  rd_data_o = {2'b0, date_q};
      A_MONTH: rd_data_o = {3'b0, month_q};
      A_YEAR:  rd_data_o = year_q;
      default: rd_data_o = {halt_q, 7'b0};
    endcase
  end

  a_r9_halt_blocks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> !sec_strobe_o);

  a_r11_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe_o |-> $past(tick_i));

  a_r5_dow_with_date: assert property (@(posedge clk) disable iff (!rst_n)
    carry_date |-> carry_hour);

  a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_year && !wr_hit[A_YEAR]) |=> (year_q == 8'h00));

  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == A_CTRL) |-> (rd_data_o[6:0] == 7'b0));

endmodule

// File: tb/tb_bcd_timekeeper.sv
`timescale 1ns/1ps
module tb_bcd_timekeeper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_strobe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_timekeeper dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .sec_strobe_o(sec_strobe));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd_reg(a, v);
    check(tag, v, e);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] dw, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr_reg(3'd2, h); wr_reg(3'd1, m); wr_reg(3'd0, s);
    wr_reg(3'd3, dw); wr_reg(3'd4, dt); wr_reg(3'd5, mo); wr_reg(3'd6, yr);
  endtask

  task automatic t_reset();
    expect_reg("R12 sec", 3'd0, 8'h00);
    expect_reg("R12 min", 3'd1, 8'h00);
    expect_reg("R12 hour", 3'd2, 8'h00);
    expect_reg("R12 dow", 3'd3, 8'h01);
    expect_reg("R12 date", 3'd4, 8'h01);
    expect_reg("R12 month", 3'd5, 8'h01);
    expect_reg("R12 year", 3'd6, 8'h00);
    expect_reg("R12 ctrl", 3'd7, 8'h00);
    check("R12 strobe", {7'b0, sec_strobe}, 8'h00);
  endtask

  task automatic t_zero_bits();
    wr_reg(3'd0, 8'hFF); expect_reg("R1 sec mask", 3'd0, 8'h7F);
    wr_reg(3'd3, 8'hFF); expect_reg("R1 dow mask", 3'd3, 8'h07);
    wr_reg(3'd4, 8'hFF); expect_reg("R1 date mask", 3'd4, 8'h3F);
    wr_reg(3'd5, 8'hFF); expect_reg("R1 month mask", 3'd5, 8'h1F);
    wr_reg(3'd7, 8'hFF); expect_reg("R1 ctrl mask", 3'd7, 8'h80);
    wr_reg(3'd7, 8'h00); expect_reg("R1 ctrl clear", 3'd7, 8'h00);
  endtask

  task automatic t_sec_min();
    set_all(8'h05, 8'h09, 8'h58, 8'h02, 8'h10, 8'h03, 8'h20);
    do_tick(); expect_reg("R2 sec 59", 3'd0, 8'h59);
    do_tick(); expect_reg("R2 sec wrap", 3'd0, 8'h00);
    expect_reg("R2 min carry", 3'd1, 8'h10);
    expect_reg("R2 hour kept", 3'd2, 8'h05);
    wr_reg(3'd1, 8'h59); wr_reg(3'd0, 8'h59);
    do_tick();
    expect_reg("R2 min wrap", 3'd1, 8'h00);
    expect_reg("R2 hour carry", 3'd2, 8'h06);
  endtask

  task automatic t_24h();
    set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h10, 8'h03, 8'h20);
    do_tick();
    expect_reg("R3 hour wrap", 3'd2, 8'h00);
    expect_reg("R3 dow carry", 3'd3, 8'h04);
    expect_reg("R3 date carry", 3'd4, 8'h11);
    set_all(8'h19, 8'h59, 8'h59, 8'h03, 8'h10, 8'h03, 8'h20);
    do_tick();
    expect_reg("R3 19 to 20", 3'd2, 8'h20);
  endtask

  task automatic t_12h();
    // AM 11 -> PM 12, no day carry
    set_all(8'h51, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h20);
    do_tick();
    expect_reg("R4 noon", 3'd2, 8'h72);
    expect_reg("R4 noon no day", 3'd3, 8'h02);
    // PM 12 -> PM 01
    wr_reg(3'd1, 8'h59); wr_reg(3'd0, 8'h59);
    do_tick();
    expect_reg("R4 one pm", 3'd2, 8'h61);
    // PM 11 -> AM 12 with day carry
    set_all(8'h71, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h20);
    do_tick();
    expect_reg("R4 midnight", 3'd2, 8'h52);
    expect_reg("R4 midnight day", 3'd3, 8'h03);
    // AM 12 -> AM 01
    wr_reg(3'd1, 8'h59); wr_reg(3'd0, 8'h59);
    do_tick();
    expect_reg("R4 one am", 3'd2, 8'h41);
    // AM 09 -> AM 10
    set_all(8'h49, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h20);
    do_tick();
    expect_reg("R4 nine to ten", 3'd2, 8'h50);
  endtask

  task automatic t_dow();
    set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h03, 8'h20);
    do_tick();
    expect_reg("R5 dow wrap", 3'd3, 8'h01);
    expect_reg("R5 date step", 3'd4, 8'h16);
  endtask

  task automatic t_month_len();
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h20);
    do_tick();
    expect_reg("R6 april end date", 3'd4, 8'h01);
    expect_reg("R6 april end month", 3'd5, 8'h05);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h05, 8'h20);
    do_tick();
    expect_reg("R6 may 31", 3'd4, 8'h31);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h11, 8'h20);
    do_tick();
    expect_reg("R6 november end", 3'd5, 8'h12);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h08, 8'h20);
    do_tick();
    expect_reg("R6 august end", 3'd5, 8'h09);
  endtask

  task automatic t_leap_sweep();
    for (int y = 0; y < 100; y++) begin
      logic [7:0] yb;
      yb = 8'(((y / 10) << 4) | (y % 10));
      set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, yb);
      do_tick();
      if (y % 4 == 0) begin
        expect_reg($sformatf("R7 leap year %0d date", y), 3'd4, 8'h29);
        expect_reg($sformatf("R7 leap year %0d month", y), 3'd5, 8'h02);
      end else begin
        expect_reg($sformatf("R7 common year %0d date", y), 3'd4, 8'h01);
        expect_reg($sformatf("R7 common year %0d month", y), 3'd5, 8'h03);
      end
    end
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h48);
    do_tick();
    expect_reg("R7 leap day end", 3'd5, 8'h03);
  endtask

  task automatic t_year_end();
    set_all(8'h23, 8'h59, 8'h59, 8'h06, 8'h31, 8'h12, 8'h99);
    do_tick();
    expect_reg("R8 year wrap", 3'd6, 8'h00);
    expect_reg("R8 month wrap", 3'd5, 8'h01);
    expect_reg("R8 date wrap", 3'd4, 8'h01);
    expect_reg("R8 hour wrap", 3'd2, 8'h00);
    set_all(8'h23, 8'h59, 8'h59, 8'h06, 8'h31, 8'h12, 8'h19);
    do_tick();
    expect_reg("R8 year step", 3'd6, 8'h20);
  endtask

  task automatic t_halt();
    set_all(8'h10, 8'h20, 8'h30, 8'h02, 8'h10, 8'h03, 8'h20);
    wr_reg(3'd7, 8'h80);
    expect_reg("R9 ctrl set", 3'd7, 8'h80);
    do_tick();
    check("R9 no strobe when stopped", {7'b0, sec_strobe}, 8'h00);
    expect_reg("R9 sec frozen", 3'd0, 8'h30);
    wr_reg(3'd0, 8'h45);
    expect_reg("R9 write while stopped", 3'd0, 8'h45);
    wr_reg(3'd7, 8'h00);
    do_tick();
    expect_reg("R9 resumes", 3'd0, 8'h46);
  endtask

  task automatic t_collide();
    set_all(8'h10, 8'h05, 8'h10, 8'h02, 8'h10, 8'h03, 8'h20);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg("R10 write beats tick", 3'd0, 8'h30);
    wr_reg(3'd0, 8'h59);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h20;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg("R10 other field ticks", 3'd0, 8'h00);
    expect_reg("R10 written minute", 3'd1, 8'h20);
  endtask

  task automatic t_strobe();
    do_tick();
    check("R11 strobe high", {7'b0, sec_strobe}, 8'h01);
    @(negedge clk);
    check("R11 strobe one cycle", {7'b0, sec_strobe}, 8'h00);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    check("R11 strobe back to back a", {7'b0, sec_strobe}, 8'h01);
    @(negedge clk);
    tick = 1'b0;
    check("R11 strobe back to back b", {7'b0, sec_strobe}, 8'h01);
    @(negedge clk);
    check("R11 strobe ends", {7'b0, sec_strobe}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_bits();
    t_sec_min();
    t_24h();
    t_12h();
    t_dow();
    t_month_len();
    t_leap_sweep();
    t_year_end();
    t_halt();
    t_collide();
    t_strobe();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule